// File: doc/BRIEF.md
# Montgomery Negated-Inverse Coefficient Engine

This block takes an odd multiword modulus N and produces the coefficient R that satisfies R·(−N) ≡ 1 (mod 2^k), where k is the operand width in bits. Montgomery multipliers use this value. The modulus is written into an internal word store, one 32-bit word per clock, least significant word first in address order. A word-count input selects the operand width at run time, as the number of words minus one. A single-cycle start pulse launches the calculation. When the ready output returns high, the coefficient can be read back word by word through a separate registered read port.

The engine works one bit at a time. R starts at 1, and a running product T = R·(−N) mod 2^k starts at −N. At each bit index i from 1 to k−1 the engine tests bit i of T. If that bit is set, it sets bit i of R and adds (−N)·2^i into T. It does this addition word-serially, with a carry that passes from word to word. There is no full multiply at any step, so the datapath is one word-wide adder and one funnel shifter.

The controller has four states. IDLE: ready is high; a start pulse captures the word count and moves the controller to NEGATE. NEGATE: one word per cycle, it forms −N as the inverted modulus plus one. It loads T with −N and R with 1. After the top word it moves to TEST with the bit index at 1. TEST: if the bit index has reached k, it returns to IDLE. If bit i of T is set, it marks bit i of R and moves to ADD at the word that holds bit i. Otherwise it increments the bit index and stays in TEST. ADD: it adds one shifted word of −N into T per cycle. After the top word it returns to TEST with the next bit index.

Top module: `mont_coef_engine`

## Requirements
- R1: After reset, ready is 1 and every result word reads as 0.
- R2: A word is written into the modulus store when mod_we is 1 at a rising clock edge. mod_addr selects the word, and address 0 holds the least significant 32 bits.
- R3: word_cnt gives the operand size as (word_cnt+1) 32-bit words, so k = 32·(word_cnt+1). Use 11 for 384 bits and 15 for 512 bits. The value is captured on the accepted start pulse.
- R4: A start pulse while ready is 1 is accepted, and ready reads 0 after the next rising edge.
- R5: A start pulse while ready is 0 is ignored. The running calculation keeps the word count it captured, and the coefficient it produces is unchanged.
- R6: For odd N, the result R is the bit-serial coefficient: R·(−N) mod 2^k = 1, with R < 2^k.
- R7: The result is read through res_addr. Address 0 holds the least significant word, and res_rdata shows the addressed word one clock after the address is applied.
- R8: Ready returns to 1 only once the full result is stored, and it stays 1 until the next accepted start.
- R9: For N = 1 the result is all ones over k bits. For N = 2^k − 1 the result is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle launch pulse |
| word_cnt | input | 4 | Operand words minus one |
| mod_we | input | 1 | Modulus word write enable |
| mod_addr | input | 4 | Modulus word address |
| mod_wdata | input | 32 | Modulus word data |
| res_addr | input | 4 | Result word address |
| res_rdata | output | 32 | Registered result word |
| ready | output | 1 | Idle and result valid |

## Verification
The running-product invariants (T odd, and the bit below the current index cleared) hold only if the modulus is odd and is not rewritten while the engine is busy. Every bench modulus therefore has its lowest bit forced to 1, and all store writes happen while ready is high. The word-range check assumes word_cnt stays within the store depth. The bench draws word counts only up to 15, and the one pulse it sends while busy carries a different count to show that the count is not taken again.

// File: rtl/mce_pkg.sv
package mce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NEGATE = 2'd1,
        ST_TEST   = 2'd2,
        ST_ADD    = 2'd3
    } mce_state_t;
endpackage

// File: rtl/mce_funnel.sv
module mce_funnel #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]         hi_word,
    input  logic [WORD_W-1:0]         lo_word,
    input  logic [$clog2(WORD_W)-1:0] shift,
    output logic [WORD_W-1:0]         out_word
);
    localparam int AMT_W = $clog2(WORD_W) + 1;

    logic [2*WORD_W-1:0] joined;
    logic [2*WORD_W-1:0] moved;
    logic [AMT_W-1:0]    amount;

    always_comb begin
        joined   = {hi_word, lo_word};
        amount   = AMT_W'(WORD_W) - AMT_W'(shift);
        moved    = joined >> amount;
        out_word = moved[WORD_W-1:0];
    end
endmodule

// File: rtl/mce_ctrl.sv
module mce_ctrl
    import mce_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    start,
    input  logic [$clog2(MAX_WORDS)-1:0]            word_cnt,
    input  logic                                    test_bit,
    output logic                                    ready,
    output logic                                    accept,
    output logic                                    do_neg,
    output logic                                    do_add,
    output logic                                    do_mark,
    output logic                                    in_test,
    output logic [$clog2(MAX_WORDS)-1:0]            widx,
    output logic [$clog2(MAX_WORDS)-1:0]            top_idx,
    output logic [$clog2(MAX_WORDS*WORD_W)+1-1:0]   bidx
);
    localparam int ADDR_W = $clog2(MAX_WORDS);
    localparam int BIT_W  = $clog2(MAX_WORDS*WORD_W) + 1;
    localparam int WSH    = $clog2(WORD_W);

    mce_state_t        state_q, state_d;
    logic [ADDR_W-1:0] widx_q, widx_d;
    logic [ADDR_W-1:0] nw_q, nw_d;
    logic [BIT_W-1:0]  bidx_q, bidx_d;
    logic [BIT_W-1:0]  k_bits;
    logic [ADDR_W-1:0] qidx;
    logic              at_end;
    logic              last_word;

    always_comb begin
        k_bits    = (BIT_W'(nw_q) + BIT_W'(1)) << WSH;
        qidx      = ADDR_W'(bidx_q >> WSH);
        at_end    = (bidx_q == k_bits);
        last_word = (widx_q == nw_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            nw_q    <= '0;
            bidx_q  <= '0;
        end else begin
            state_q <= state_d;
            widx_q  <= widx_d;
            nw_q    <= nw_d;
            bidx_q  <= bidx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        widx_d  = widx_q;
        nw_d    = nw_q;
        bidx_d  = bidx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_NEGATE;
                    widx_d  = '0;
                    nw_d    = word_cnt;
                end
            end
            ST_NEGATE: begin
                if (last_word) begin
                    state_d = ST_TEST;
                    bidx_d  = BIT_W'(1);
                end else begin
                    widx_d = widx_q + ADDR_W'(1);
                end
            end
            ST_TEST: begin
                if (at_end) begin
                    state_d = ST_IDLE;
                end else if (test_bit) begin
                    state_d = ST_ADD;
                    widx_d  = qidx;
                end else begin
                    bidx_d = bidx_q + BIT_W'(1);
                end
            end
            ST_ADD: begin
                if (last_word) begin
                    state_d = ST_TEST;
                    bidx_d  = bidx_q + BIT_W'(1);
                end else begin
                    widx_d = widx_q + ADDR_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready   = (state_q == ST_IDLE);
        accept  = (state_q == ST_IDLE) && start;
        do_neg  = (state_q == ST_NEGATE);
        do_add  = (state_q == ST_ADD);
        in_test = (state_q == ST_TEST) && !at_end;
        do_mark = in_test && test_bit;
        widx    = widx_q;
        top_idx = nw_q;
        bidx    = bidx_q;
    end

    assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start) |=> (nw_q == $past(nw_q)));

    assert_word_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_neg || do_add) |-> (widx_q <= nw_q));

    assert_add_from_bit_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_add |-> (widx_q >= qidx));
endmodule

// File: rtl/mce_datapath.sv
module mce_datapath #(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  accept,
    input  logic                                  do_neg,
    input  logic                                  do_add,
    input  logic                                  do_mark,
    input  logic                                  in_test,
    input  logic [$clog2(MAX_WORDS)-1:0]          widx,
    input  logic [$clog2(MAX_WORDS*WORD_W)+1-1:0] bidx,
    input  logic                                  mod_we,
    input  logic [$clog2(MAX_WORDS)-1:0]          mod_addr,
    input  logic [WORD_W-1:0]                     mod_wdata,
    input  logic [$clog2(MAX_WORDS)-1:0]          res_addr,
    output logic [WORD_W-1:0]                     res_rdata,
    output logic                                  test_bit
);
    localparam int ADDR_W = $clog2(MAX_WORDS);
    localparam int BIT_W  = $clog2(MAX_WORDS*WORD_W) + 1;
    localparam int WSH    = $clog2(WORD_W);

    logic [WORD_W-1:0] nmem [MAX_WORDS];
    logic [WORD_W-1:0] negn [MAX_WORDS];
    logic [WORD_W-1:0] tmem [MAX_WORDS];
    logic [WORD_W-1:0] rmem [MAX_WORDS];

    logic              carry_q;
    logic [ADDR_W-1:0] qidx;
    logic [WSH-1:0]    sidx;
    logic [ADDR_W-1:0] hi_idx, lo_idx;
    logic              first_word;
    logic [WORD_W-1:0] hi_src, lo_src, shifted;
    logic [WORD_W-1:0] add_a, add_b;
    logic [WORD_W:0]   sum;
    logic [BIT_W-1:0]  pidx;
    logic              prev_bit;

    always_comb begin
        qidx       = ADDR_W'(bidx >> WSH);
        sidx       = bidx[WSH-1:0];
        hi_idx     = widx - qidx;
        lo_idx     = hi_idx - ADDR_W'(1);
        first_word = (widx == qidx);
        hi_src     = negn[hi_idx];
        lo_src     = first_word ? '0 : negn[lo_idx];
        test_bit   = tmem[qidx][sidx];
        pidx       = bidx - BIT_W'(1);
        prev_bit   = tmem[ADDR_W'(pidx >> WSH)][pidx[WSH-1:0]];
    end

    mce_funnel #(.WORD_W(WORD_W)) u_funnel (
        .hi_word (hi_src),
        .lo_word (lo_src),
        .shift   (sidx),
        .out_word(shifted)
    );

    always_comb begin
        if (do_neg) begin
            add_a = ~nmem[widx];
            add_b = '0;
        end else begin
            add_a = tmem[widx];
            add_b = shifted;
        end
        sum = {1'b0, add_a} + {1'b0, add_b} + {{WORD_W{1'b0}}, carry_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < MAX_WORDS; w++) nmem[w] <= '0;
        end else if (mod_we) begin
            nmem[mod_addr] <= mod_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            for (int w = 0; w < MAX_WORDS; w++) begin
                negn[w] <= '0;
                tmem[w] <= '0;
                rmem[w] <= '0;
            end
        end else begin
            if (accept) begin
                carry_q <= 1'b1;
            end else if (do_mark) begin
                carry_q <= 1'b0;
            end else if (do_neg || do_add) begin
                carry_q <= sum[WORD_W];
            end
            if (do_neg) begin
                negn[widx] <= sum[WORD_W-1:0];
                tmem[widx] <= sum[WORD_W-1:0];
                rmem[widx] <= (widx == '0) ? WORD_W'(1) : '0;
            end
            if (do_add) begin
                tmem[widx] <= sum[WORD_W-1:0];
            end
            if (do_mark) begin
                rmem[qidx][sidx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_rdata <= '0;
        else        res_rdata <= rmem[res_addr];
    end

    assert_product_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_test |-> tmem[0][0]);

    assert_low_bit_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_test && bidx > BIT_W'(1)) |-> !prev_bit);

    assert_result_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_test |-> rmem[0][0]);
endmodule

// File: rtl/mont_coef_engine.sv
module mont_coef_engine #(
    parameter int WORD_W    = 32,
    parameter int MAX_WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAX_WORDS)-1:0] word_cnt,
    input  logic                         mod_we,
    input  logic [$clog2(MAX_WORDS)-1:0] mod_addr,
    input  logic [WORD_W-1:0]            mod_wdata,
    input  logic [$clog2(MAX_WORDS)-1:0] res_addr,
    output logic [WORD_W-1:0]            res_rdata,
    output logic                         ready
);
    localparam int ADDR_W = $clog2(MAX_WORDS);
    localparam int BIT_W  = $clog2(MAX_WORDS*WORD_W) + 1;

    logic              accept, do_neg, do_add, do_mark, in_test, test_bit;
    logic [ADDR_W-1:0] widx, top_idx;
    logic [BIT_W-1:0]  bidx;

    mce_ctrl #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .word_cnt(word_cnt),
        .test_bit(test_bit),
        .ready   (ready),
        .accept  (accept),
        .do_neg  (do_neg),
        .do_add  (do_add),
        .do_mark (do_mark),
        .in_test (in_test),
        .widx    (widx),
        .top_idx (top_idx),
        .bidx    (bidx)
    );

    mce_datapath #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .do_neg   (do_neg),
        .do_add   (do_add),
        .do_mark  (do_mark),
        .in_test  (in_test),
        .widx     (widx),
        .bidx     (bidx),
        .mod_we   (mod_we),
        .mod_addr (mod_addr),
        .mod_wdata(mod_wdata),
        .res_addr (res_addr),
        .res_rdata(res_rdata),
        .test_bit (test_bit)
    );

    assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready);

    assert_finish_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready)) |-> ($past(bidx) == ((BIT_W'(top_idx) + BIT_W'(1)) << $clog2(WORD_W))));
endmodule

// File: tb/mont_coef_engine_test.sv
module mont_coef_engine_test;
    localparam int WORD_W = 32;
    localparam int MAXW   = 16;
    localparam int KMAX   = WORD_W * MAXW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        word_cnt = '0;
    logic              mod_we = 1'b0;
    logic [3:0]        mod_addr = '0;
    logic [WORD_W-1:0] mod_wdata = '0;
    logic [3:0]        res_addr = '0;
    logic [WORD_W-1:0] res_rdata;
    logic              ready;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    mont_coef_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_cnt(word_cnt),
        .mod_we(mod_we), .mod_addr(mod_addr), .mod_wdata(mod_wdata),
        .res_addr(res_addr), .res_rdata(res_rdata), .ready(ready)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual cycles %0d expected under 190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string req, input logic [KMAX-1:0] act, input logic [KMAX-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [KMAX-1:0] kmask(input int words);
        return (words == MAXW) ? '1 : ((KMAX'(1) << (words * WORD_W)) - KMAX'(1));
    endfunction

    function automatic logic [KMAX-1:0] model(input logic [KMAX-1:0] n, input int words);
        logic [KMAX-1:0] m, nn, r, t;
        m  = kmask(words);
        nn = (~n + KMAX'(1)) & m;
        r  = KMAX'(1);
        for (int i = 1; i < words * WORD_W; i++) begin
            t = (r * nn) & m;
            if (t[i]) r[i] = 1'b1;
        end
        return r;
    endfunction

    task automatic load(input logic [KMAX-1:0] n, input int words);
        for (int w = 0; w < words; w++) begin
            @(negedge clk);
            mod_we    = 1'b1;
            mod_addr  = 4'(w);
            mod_wdata = n[w*WORD_W +: WORD_W];
        end
        @(negedge clk);
        mod_we = 1'b0;
    endtask

    task automatic read_res(input int words, output logic [KMAX-1:0] r);
        r = '0;
        for (int w = 0; w < words; w++) begin
            @(negedge clk);
            res_addr = 4'(w);
            @(negedge clk);
            r[w*WORD_W +: WORD_W] = res_rdata;
        end
    endtask

    task automatic run_case(input logic [KMAX-1:0] n_in, input int words, input bit poke_busy,
                            input bit has_exp, input logic [KMAX-1:0] exp_fixed);
        logic [KMAX-1:0] n, got, exp_r, prod;
        n = (n_in & kmask(words)) | KMAX'(1);
        load(n, words);
        @(negedge clk);
        word_cnt = 4'(words - 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4 ready low after start", KMAX'(ready), KMAX'(0));
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            word_cnt = 4'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R5 busy start ignored, still busy", KMAX'(ready), KMAX'(0));
        end
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R8 ready stays high when idle", KMAX'(ready), KMAX'(1));
        read_res(words, got);
        exp_r = has_exp ? exp_fixed : model(n, words);
        check(poke_busy ? "R5 R6 coefficient" : "R6 R3 R7 coefficient", got, exp_r);
        prod = (got * ((~n + KMAX'(1)) & kmask(words))) & kmask(words);
        check("R6 product is one", prod, KMAX'(1));
    endtask

    function automatic logic [KMAX-1:0] rand_wide();
        logic [KMAX-1:0] v;
        for (int w = 0; w < MAXW; w++) v[w*WORD_W +: WORD_W] = $urandom();
        return v;
    endfunction

    initial begin
        logic [KMAX-1:0] r0;
        void'($urandom(32'h1234abcd));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", KMAX'(ready), KMAX'(1));
        read_res(MAXW, r0);
        check("R1 result cleared after reset", r0, '0);

        // R9 corners at 384 bits and 512 bits
        run_case(KMAX'(1), 12, 1'b0, 1'b1, kmask(12));
        run_case('1, 16, 1'b0, 1'b1, KMAX'(1));
        run_case(KMAX'(1), 16, 1'b0, 1'b1, '1);
        // R3 single-word operand
        run_case(rand_wide(), 1, 1'b0, 1'b0, '0);
        // R2 R6 random moduli at 384 and 512 bits
        for (int c = 0; c < 3; c++) run_case(rand_wide(), 12, 1'b0, 1'b0, '0);
        for (int c = 0; c < 3; c++) run_case(rand_wide(), 16, 1'b0, 1'b0, '0);
        // R5 start pulse during run with different word count
        run_case(rand_wide(), 16, 1'b1, 1'b0, '0);
        run_case(rand_wide(), 5, 1'b0, 1'b0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule